// File: doc/BRIEF.md
# Line-Address Stall-and-Wake Request Buffer

This block sits in front of a coherence controller and chooses one message per cycle from three input ports. The response port is never held back. The forwarded-request port and the core-request port are served by fixed rank below it. For every request it chooses, the block asks the controller whether the target line is stable, using a combinational lookup. If the line is in a transient state, the request is accepted from its port and placed in a small wait store, tagged with its line address. It is not replayed on a timer and does not block the port, so requests to other lines keep flowing.

The controller sends a wakeup strobe with a line address when that line becomes stable. Every parked entry with that address is then marked as woken. Woken entries are handed back to the controller one per cycle, oldest first. Each woken entry is looked up again, and an entry whose line has turned transient again returns to waiting in the same place. A new request for a line that still has sleeping entries is parked behind them. This means a younger request cannot overtake an older one for the same line. When the store is full, a request that would need to park sees its port's ready held low until an entry frees. No request is ever dropped.

Top module: `stall_wake_buffer`

## Requirements
- R1: A response (rank 2) is always accepted (`rsp_ready` is high) and issued in the same cycle with `out_src`=2 and `out_replay`=0, ahead of every other source. Responses are never parked.
- R2: When no response and no woken entry is present, a forwarded request (`out_src`=1) is chosen over a core request (`out_src`=0). Only the chosen port sees ready high.
- R3: A chosen arrival whose lookup returns `lk_stable`=0 is accepted (ready high) but not issued (`out_valid`=0) in that cycle, and it enters the wait store.
- R4: A chosen arrival whose line matches a parked entry that is not woken is parked too, even when `lk_stable`=1.
- R5: A parked entry stays parked until a wakeup carries its exact address. A wakeup for an address with no parked entries changes nothing.
- R6: Woken entries are issued one per cycle with `out_replay`=1, oldest arrival first, with their original source, address and data. They go ahead of any new request arrival but behind a response.
- R7: A woken entry whose lookup returns `lk_stable`=0 is not issued. It goes back to waiting in its place and needs a further wakeup.
- R8: A chosen arrival to a stable line with no parked entries is issued in the same cycle with `out_replay`=0, past any parked entries for other lines.
- R9: With the store holding DEPTH entries, an arrival that would park sees its ready low and is kept at the port. An arrival that can be issued is still accepted.
- R10: `lk_addr` presents the address of the current candidate: the response if valid, else the oldest woken entry, else the forwarded request, else the core request.
- R11: A wakeup in the same cycle as a park for the same address wakes the newly parked entry.
- R12: After reset the store is empty, `out_valid` is low and no replay is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | Response message present |
| rsp_ready | output | 1 | Response accepted |
| rsp_addr | input | ADDR_W | Response line address |
| rsp_data | input | DATA_W | Response payload |
| fwd_valid | input | 1 | Forwarded request present |
| fwd_ready | output | 1 | Forwarded request accepted |
| fwd_addr | input | ADDR_W | Forwarded request line address |
| fwd_data | input | DATA_W | Forwarded request payload |
| core_valid | input | 1 | Core request present |
| core_ready | output | 1 | Core request accepted |
| core_addr | input | ADDR_W | Core request line address |
| core_data | input | DATA_W | Core request payload |
| lk_addr | output | ADDR_W | Line address being looked up |
| lk_stable | input | 1 | Controller reports that line is stable |
| wake_valid | input | 1 | Line has become stable |
| wake_addr | input | ADDR_W | Address of the line that became stable |
| out_valid | output | 1 | Message issued to controller |
| out_src | output | 2 | Source of message: 2 response, 1 forwarded, 0 core |
| out_replay | output | 1 | Message comes from the wait store |
| out_addr | output | ADDR_W | Issued line address |
| out_data | output | DATA_W | Issued payload |

## Verification
The bench builds the block with DEPTH=4, ADDR_W=4 and DATA_W=8. With 16 lines, the controller's stable map fits in one vector that drives the lookup, and four parks are enough to fill the store. All eight combinations of the three valid inputs are swept to check rank and lookup address. Directed sequences then cover parking, same-line ordering, stray wakeups, re-parking after a lookup that is transient again, a full store, and a wakeup in the same cycle as a park.

// File: rtl/swb_pkg.sv
package swb_pkg;
   typedef enum logic [1:0] {
      SRC_CORE = 2'd0,
      SRC_FWD  = 2'd1,
      SRC_RSP  = 2'd2
   } src_e;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_RSP,
      SEL_WOKEN,
      SEL_FWD,
      SEL_CORE
   } sel_e;
endpackage

// File: rtl/swb_arbiter.sv
module swb_arbiter
   import swb_pkg::*;
(
   input  logic rsp_v,
   input  logic wok_v,
   input  logic fwd_v,
   input  logic core_v,
   output sel_e sel
);
   // rank: response, then drained waiters, then forwarded, then core
   always_comb begin
      if (rsp_v)       sel = SEL_RSP;
      else if (wok_v)  sel = SEL_WOKEN;
      else if (fwd_v)  sel = SEL_FWD;
      else if (core_v) sel = SEL_CORE;
      else             sel = SEL_NONE;
   end
endmodule

// File: rtl/swb_wait_store.sv
module swb_wait_store #(
   parameter  int DEPTH  = 4,
   parameter  int ADDR_W = 8,
   parameter  int DATA_W = 16,
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [1:0]        push_src_i,
   input  logic [ADDR_W-1:0] push_addr_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   input  logic              unwake_i,
   input  logic [IDX_W-1:0]  sel_idx_i,
   input  logic              wake_i,
   input  logic [ADDR_W-1:0] wake_addr_i,
   input  logic [ADDR_W-1:0] probe_addr_i,
   output logic              full_o,
   output logic              probe_hit_o,
   output logic              woken_any_o,
   output logic [IDX_W-1:0]  woken_idx_o,
   output logic [1:0]        woken_src_o,
   output logic [ADDR_W-1:0] woken_addr_o,
   output logic [DATA_W-1:0] woken_data_o,
   output logic [CNT_W-1:0]  count_o
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("swb_wait_store: DEPTH must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("swb_wait_store: widths must be positive");
   end

   // entries kept in arrival order, index 0 oldest
   logic [1:0]        e_src  [DEPTH];
   logic [ADDR_W-1:0] e_addr [DEPTH];
   logic [DATA_W-1:0] e_data [DEPTH];
   logic              e_wok  [DEPTH];
   logic [CNT_W-1:0]  cnt;

   logic [1:0]        up_src  [DEPTH];
   logic [ADDR_W-1:0] up_addr [DEPTH];
   logic [DATA_W-1:0] up_data [DEPTH];
   logic              up_wok  [DEPTH];

   logic [1:0]        n_src  [DEPTH];
   logic [ADDR_W-1:0] n_addr [DEPTH];
   logic [DATA_W-1:0] n_data [DEPTH];
   logic              n_wok  [DEPTH];
   logic [CNT_W-1:0]  n_cnt;

   for (genvar g = 0; g < DEPTH; g++) begin : g_shift
      if (g < DEPTH - 1) begin : g_mid
         assign up_src[g]  = e_src[g+1];
         assign up_addr[g] = e_addr[g+1];
         assign up_data[g] = e_data[g+1];
         assign up_wok[g]  = e_wok[g+1];
      end else begin : g_top
         assign up_src[g]  = '0;
         assign up_addr[g] = '0;
         assign up_data[g] = '0;
         assign up_wok[g]  = 1'b0;
      end
   end

   always_comb begin
      n_cnt = cnt;
      for (int i = 0; i < DEPTH; i++) begin
         n_src[i]  = e_src[i];
         n_addr[i] = e_addr[i];
         n_data[i] = e_data[i];
         n_wok[i]  = e_wok[i];
      end
      if (pop_i) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (IDX_W'(i) >= sel_idx_i) begin
               n_src[i]  = up_src[i];
               n_addr[i] = up_addr[i];
               n_data[i] = up_data[i];
               n_wok[i]  = up_wok[i];
            end
         end
         n_cnt = cnt - 1'b1;
      end
      if (push_i) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) == cnt) begin
               n_src[i]  = push_src_i;
               n_addr[i] = push_addr_i;
               n_data[i] = push_data_i;
               n_wok[i]  = 1'b0;
            end
         end
         n_cnt = cnt + 1'b1;
      end
      if (unwake_i) n_wok[sel_idx_i] = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (wake_i && CNT_W'(i) < n_cnt && n_addr[i] == wake_addr_i) n_wok[i] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            e_src[i]  <= '0;
            e_addr[i] <= '0;
            e_data[i] <= '0;
            e_wok[i]  <= 1'b0;
         end
      end else begin
         cnt <= n_cnt;
         for (int i = 0; i < DEPTH; i++) begin
            e_src[i]  <= n_src[i];
            e_addr[i] <= n_addr[i];
            e_data[i] <= n_data[i];
            e_wok[i]  <= n_wok[i];
         end
      end
   end

   always_comb begin
      woken_any_o = 1'b0;
      woken_idx_o = '0;
      probe_hit_o = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!woken_any_o && CNT_W'(i) < cnt && e_wok[i]) begin
            woken_any_o = 1'b1;
            woken_idx_o = IDX_W'(i);
         end
         if (CNT_W'(i) < cnt && !e_wok[i] && e_addr[i] == probe_addr_i) probe_hit_o = 1'b1;
      end
   end

   assign woken_src_o  = e_src[woken_idx_o];
   assign woken_addr_o = e_addr[woken_idx_o];
   assign woken_data_o = e_data[woken_idx_o];
   assign full_o       = (cnt == CNT_W'(DEPTH));
   assign count_o      = cnt;

   a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   a_r6_one_op: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({push_i, pop_i, unwake_i}));
   a_r6_pop_needs_woken: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> woken_any_o);
endmodule

// File: rtl/stall_wake_buffer.sv
module stall_wake_buffer
   import swb_pkg::*;
#(
   parameter  int DEPTH  = 4,
   parameter  int ADDR_W = 8,
   parameter  int DATA_W = 16,
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsp_valid,
   output logic              rsp_ready,
   input  logic [ADDR_W-1:0] rsp_addr,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic              fwd_valid,
   output logic              fwd_ready,
   input  logic [ADDR_W-1:0] fwd_addr,
   input  logic [DATA_W-1:0] fwd_data,
   input  logic              core_valid,
   output logic              core_ready,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic [DATA_W-1:0] core_data,
   output logic [ADDR_W-1:0] lk_addr,
   input  logic              lk_stable,
   input  logic              wake_valid,
   input  logic [ADDR_W-1:0] wake_addr,
   output logic              out_valid,
   output logic [1:0]        out_src,
   output logic              out_replay,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data
);
   sel_e              sel;
   logic              full, probe_hit, wok_any;
   logic [IDX_W-1:0]  wok_idx;
   logic [1:0]        wok_src;
   logic [ADDR_W-1:0] wok_addr;
   logic [DATA_W-1:0] wok_data;
   logic [CNT_W-1:0]  count;

   logic [1:0]        cand_src;
   logic [ADDR_W-1:0] cand_addr;
   logic [DATA_W-1:0] cand_data;
   logic              is_arrival, must_wait, issue_arr, park, wk_go, wk_back;

   swb_arbiter u_arb (
      .rsp_v  (rsp_valid),
      .wok_v  (wok_any),
      .fwd_v  (fwd_valid),
      .core_v (core_valid),
      .sel    (sel)
   );

   always_comb begin
      cand_src  = SRC_CORE;
      cand_addr = core_addr;
      cand_data = core_data;
      case (sel)
         SEL_RSP: begin
            cand_src  = SRC_RSP;
            cand_addr = rsp_addr;
            cand_data = rsp_data;
         end
         SEL_WOKEN: begin
            cand_src  = wok_src;
            cand_addr = wok_addr;
            cand_data = wok_data;
         end
         SEL_FWD: begin
            cand_src  = SRC_FWD;
            cand_addr = fwd_addr;
            cand_data = fwd_data;
         end
         default: ;
      endcase
   end

   assign is_arrival = (sel == SEL_FWD) || (sel == SEL_CORE);
   assign must_wait  = !lk_stable || probe_hit;
   assign issue_arr  = is_arrival && !must_wait;
   assign park       = is_arrival && must_wait && !full;
   assign wk_go      = (sel == SEL_WOKEN) && lk_stable;
   assign wk_back    = (sel == SEL_WOKEN) && !lk_stable;

   swb_wait_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .push_i       (park),
      .push_src_i   (cand_src),
      .push_addr_i  (cand_addr),
      .push_data_i  (cand_data),
      .pop_i        (wk_go),
      .unwake_i     (wk_back),
      .sel_idx_i    (wok_idx),
      .wake_i       (wake_valid),
      .wake_addr_i  (wake_addr),
      .probe_addr_i (cand_addr),
      .full_o       (full),
      .probe_hit_o  (probe_hit),
      .woken_any_o  (wok_any),
      .woken_idx_o  (wok_idx),
      .woken_src_o  (wok_src),
      .woken_addr_o (wok_addr),
      .woken_data_o (wok_data),
      .count_o      (count)
   );

   assign lk_addr    = cand_addr;
   assign rsp_ready  = 1'b1;
   assign fwd_ready  = (sel == SEL_FWD)  && (issue_arr || park);
   assign core_ready = (sel == SEL_CORE) && (issue_arr || park);
   assign out_valid  = (sel == SEL_RSP) || wk_go || issue_arr;
   assign out_replay = wk_go;
   assign out_src    = cand_src;
   assign out_addr   = cand_addr;
   assign out_data   = cand_data;

   a_r1_rsp_first: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (out_valid && out_src == 2'd2 && !out_replay));
   a_r2_one_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_valid && rsp_ready, fwd_valid && fwd_ready, core_valid && core_ready}));
   a_r3_park_grows: assert property (@(posedge clk) disable iff (!rst_n)
      ((fwd_valid && fwd_ready) || (core_valid && core_ready)) && !out_valid
      |=> count == $past(count) + 1'b1);
   a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH) && core_valid && core_ready) |-> out_valid);
endmodule

// File: tb/test_stall_wake_buffer.sv
module test_stall_wake_buffer;
   localparam int AW = 4;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n;
   logic rsp_valid, fwd_valid, core_valid, wake_valid;
   logic rsp_ready, fwd_ready, core_ready;
   logic [AW-1:0] rsp_addr, fwd_addr, core_addr, wake_addr, lk_addr, out_addr;
   logic [DW-1:0] rsp_data, fwd_data, core_data, out_data;
   logic lk_stable, out_valid, out_replay;
   logic [1:0] out_src;
   logic [15:0] trans;
   int checks = 0;
   int fails = 0;

   always #4 clk = ~clk;

   // controller model: a line is stable unless its transient bit is set
   assign lk_stable = !trans[lk_addr];

   stall_wake_buffer #(.DEPTH(4), .ADDR_W(AW), .DATA_W(DW)) i_stall_wake_buffer (
      .clk(clk), .rst_n(rst_n),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
      .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
      .core_valid(core_valid), .core_ready(core_ready), .core_addr(core_addr), .core_data(core_data),
      .lk_addr(lk_addr), .lk_stable(lk_stable),
      .wake_valid(wake_valid), .wake_addr(wake_addr),
      .out_valid(out_valid), .out_src(out_src), .out_replay(out_replay),
      .out_addr(out_addr), .out_data(out_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic adv();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      rsp_valid = 0; fwd_valid = 0; core_valid = 0; wake_valid = 0;
      rsp_addr = 0; fwd_addr = 0; core_addr = 0; wake_addr = 0;
      rsp_data = 0; fwd_data = 0; core_data = 0;
   endtask

   task automatic core_req(input logic [AW-1:0] a, input logic [DW-1:0] d);
      core_valid = 1; core_addr = a; core_data = d;
   endtask

   task automatic expect_replay(input string tag, input logic [1:0] s, input logic [AW-1:0] a,
                                input logic [DW-1:0] d);
      chk({tag, " out_valid"}, 32'(out_valid), 1);
      chk({tag, " replay"}, 32'(out_replay), 1);
      chk({tag, " src"}, 32'(out_src), 32'(s));
      chk({tag, " addr"}, 32'(out_addr), 32'(a));
      chk({tag, " data"}, 32'(out_data), 32'(d));
   endtask

   initial begin
      #100000;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 0; trans = '0; idle();
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      #3;
      // R12 reset state
      chk("R12 out_valid", 32'(out_valid), 0);
      chk("R12 rsp_ready", 32'(rsp_ready), 1);
      chk("R12 core_ready", 32'(core_ready), 0);
      adv();
      #3;
      chk("R12 no replay", 32'(out_valid), 0);
      adv();

      // R1 R2 R8 R10: sweep of all valid combinations, all lines stable
      for (int v = 0; v < 8; v++) begin
         idle();
         rsp_valid = v[2]; fwd_valid = v[1]; core_valid = v[0];
         rsp_addr = 1; fwd_addr = 2; core_addr = 4;
         rsp_data = 8'h11; fwd_data = 8'h22; core_data = 8'h44;
         #3;
         chk("R1 R8 out_valid", 32'(out_valid), 32'(v != 0));
         chk("R2 fwd_ready", 32'(fwd_ready), 32'(v[1] && !v[2]));
         chk("R2 core_ready", 32'(core_ready), 32'(v[0] && !v[1] && !v[2]));
         if (v != 0) begin
            chk("R2 src", 32'(out_src), v[2] ? 2 : (v[1] ? 1 : 0));
            chk("R1 data", 32'(out_data), v[2] ? 32'h11 : (v[1] ? 32'h22 : 32'h44));
            chk("R10 lk_addr", 32'(lk_addr), v[2] ? 1 : (v[1] ? 2 : 4));
            chk("R8 replay", 32'(out_replay), 0);
         end
         adv();
      end

      // parking, same-line order, stray wake
      idle(); trans[5] = 1;
      core_req(5, 8'hA0); #3;
      chk("R3 core_ready", 32'(core_ready), 1);
      chk("R3 out_valid", 32'(out_valid), 0);
      adv();
      idle(); fwd_valid = 1; fwd_addr = 5; fwd_data = 8'hB1; #3;
      chk("R3 fwd park", 32'(fwd_ready && !out_valid), 1);
      adv();
      idle(); core_req(6, 8'hC6); #3;
      chk("R8 bypass valid", 32'(out_valid), 1);
      chk("R8 bypass data", 32'(out_data), 32'hC6);
      adv();
      idle(); trans[5] = 0; core_req(5, 8'hC2); #3;
      chk("R4 held behind", 32'(out_valid), 0);
      chk("R4 accepted", 32'(core_ready), 1);
      adv();
      idle(); wake_valid = 1; wake_addr = 9; #3;
      adv();
      idle(); #3;
      chk("R5 stray wake", 32'(out_valid), 0);
      adv();
      idle(); wake_valid = 1; wake_addr = 5; #3;
      chk("R5 wake cycle", 32'(out_valid), 0);
      adv();
      idle(); core_req(7, 8'h77); rsp_valid = 1; rsp_addr = 1; rsp_data = 8'hE1; #3;
      chk("R1 rsp over replay", 32'(out_src), 2);
      chk("R1 rsp replay flag", 32'(out_replay), 0);
      chk("R6 core held", 32'(core_ready), 0);
      adv();
      rsp_valid = 0; #3;
      expect_replay("R6 first", 2'd0, 5, 8'hA0);
      chk("R6 core held2", 32'(core_ready), 0);
      adv(); #3;
      expect_replay("R6 second", 2'd1, 5, 8'hB1);
      adv(); #3;
      expect_replay("R6 third", 2'd0, 5, 8'hC2);
      adv(); #3;
      chk("R6 new after drain", 32'(out_valid && !out_replay && out_data == 8'h77 && core_ready), 1);
      adv();

      // re-park after transient lookup
      idle(); trans[3] = 1;
      core_req(3, 8'h33); adv();
      core_req(3, 8'h34); adv();
      idle(); wake_valid = 1; wake_addr = 3; adv();
      idle(); #3;
      chk("R10 woken lk_addr", 32'(lk_addr), 3);
      chk("R7 not issued", 32'(out_valid), 0);
      adv(); #3;
      chk("R7 second not issued", 32'(out_valid), 0);
      adv(); #3;
      chk("R7 waits again", 32'(out_valid), 0);
      adv();
      trans[3] = 0; wake_valid = 1; wake_addr = 3; adv();
      idle(); #3;
      expect_replay("R7 rewake a", 2'd0, 3, 8'h33);
      adv(); #3;
      expect_replay("R7 rewake b", 2'd0, 3, 8'h34);
      adv(); #3;
      chk("R7 empty", 32'(out_valid), 0);
      adv();

      // full store
      idle(); trans[8] = 1;
      for (int k = 0; k < 4; k++) begin
         core_req(8, 8'h80 + 8'(k)); #3;
         chk("R9 fill ready", 32'(core_ready), 1);
         adv();
      end
      core_req(8, 8'h84); #3;
      chk("R9 full ready low", 32'(core_ready), 0);
      chk("R9 full no out", 32'(out_valid), 0);
      adv();
      core_req(2, 8'h22); #3;
      chk("R9 issuable accepted", 32'(core_ready && out_valid && out_data == 8'h22), 1);
      adv();
      core_req(8, 8'h84); trans[8] = 0; wake_valid = 1; wake_addr = 8; #3;
      chk("R9 still held", 32'(core_ready), 0);
      adv();
      wake_valid = 0;
      for (int k = 0; k < 4; k++) begin
         #3;
         expect_replay("R9 drain", 2'd0, 8, 8'h80 + 8'(k));
         chk("R9 drain hold", 32'(core_ready), 0);
         adv();
      end
      #3;
      chk("R9 kept request", 32'(core_ready && out_valid && !out_replay && out_data == 8'h84), 1);
      adv();

      // wake in the same cycle as park
      idle(); trans[12] = 1; core_req(12, 8'hC0); wake_valid = 1; wake_addr = 12; #3;
      chk("R11 parked", 32'(core_ready && !out_valid), 1);
      adv();
      idle(); trans[12] = 0; #3;
      expect_replay("R11 woken", 2'd0, 12, 8'hC0);
      adv();

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule